// File: doc/BRIEF.md
# Microcontroller Interrupt Controller

This block collects interrupt requests for a small 8-bit processor core and decides when to interrupt it. It watches three sources: an external request pin, a one-cycle overflow pulse from the main timer, and a change on the upper four bits of a general purpose input port. Each source sets its own sticky flag bit in an 8-bit control register. The same register holds one enable bit per source and a global enable bit. The processor reads and writes the register through a simple write strobe and a combinational read bus.

When the global enable is set and at least one source has both its flag and its enable set, a small sequencer raises a request toward the control unit. The control unit answers with an acknowledge. The block then clears the global enable, pulses a push strobe so the return address is saved, and presents a fixed vector address. A return-from-interrupt strobe sets the global enable again. Flags are cleared only by software.

The sequencer has three states. `ST_IDLE` moves to `ST_REQ` when an interrupt is pending. `ST_REQ` moves to `ST_PUSH` on acknowledge, or back to `ST_IDLE` if the pending condition goes away first. `ST_PUSH` always returns to `ST_IDLE` after one cycle.

Top module: `mcu_irq_unit`

## Requirements
- R1: After reset the control register reads 0x00, and both `irq_req` and `push_ret` are low.
- R2: Control register bits: bit7 global enable, bit5 timer enable, bit4 external enable, bit3 port-change enable, bit2 timer flag, bit1 external flag, bit0 port-change flag. Bit6 always reads 0, so writing 0xFF reads back 0xBF.
- R3: A `tmr_ovf` pulse sets the timer flag at the clock edge that samples it, whatever the enables are.
- R4: The external pin passes two synchronizer flops. The external flag is set at the third clock edge after the pin changes. When `ext_rise_sel` is 1 only a 0-to-1 change counts; when it is 0 only a 1-to-0 change counts. The other edge has no effect.
- R5: The port-change flag is set when the synchronized `port_hi` differs from a snapshot. The snapshot is reloaded from the synchronized value on each `port_rd` strobe, so after a read of the current value the flag does not set again.
- R6: `irq_req` rises one cycle after the global enable and some enabled flag are both visible in the register, and never without the global enable.
- R7: An `irq_ack` sampled while `irq_req` is high produces a one-cycle `push_ret` in the next cycle. In that cycle `irq_req` is low and the global enable reads 0. `vec_addr` always equals 0x0004.
- R8: Taking an interrupt leaves every flag bit set.
- R9: A `reti` strobe sets the global enable at that clock edge.
- R10: When a software write clears a flag in the same cycle that hardware sets it, the flag ends up set.
- R11: If the pending condition disappears while `irq_req` is high and no acknowledge has come, `irq_req` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_pin | input | 1 | External interrupt pin, asynchronous |
| ext_rise_sel | input | 1 | 1: rising edge counts, 0: falling edge counts |
| tmr_ovf | input | 1 | Timer overflow pulse |
| port_hi | input | 4 | Upper port bits watched for change |
| port_rd | input | 1 | CPU read of the port; reloads the snapshot |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register read data |
| irq_ack | input | 1 | Control unit accepts the request |
| reti | input | 1 | Return-from-interrupt strobe |
| irq_req | output | 1 | Interrupt request to the control unit |
| push_ret | output | 1 | Push return address strobe |
| vec_addr | output | 16 | Fixed interrupt vector |

## Verification
A timer pulse shows in the register one edge later, and the request follows one edge after that. The external pin and port bits need three edges to reach their flags. Push and the cleared global enable appear one edge after acknowledge. A withdrawn request falls two edges after the write that removes it, because the sequencer looks at the old register value at the write edge. The bench drives inputs just after a rising edge and samples after a counted number of edges, at the exact edge for timing-critical checks and after a settled margin in the vector loop.

// File: rtl/irq_pkg.sv
package irq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_PUSH = 2'd2
    } irq_state_t;

    localparam int NSRC   = 3;
    localparam int GIE_B  = 7;
    localparam int EN_LO  = 3;
    localparam int FLG_LO = 0;
    localparam int SRC_TMR = 2;
    localparam int SRC_EXT = 1;
    localparam int SRC_PCH = 0;
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic rise_sel,
    output logic evt
);
    logic [STAGES:0] chain;
    logic now_v, old_v;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-1:0], pin};
    end

    assign now_v = chain[STAGES-1];
    assign old_v = chain[STAGES];
    assign evt   = rise_sel ? (now_v & ~old_v) : (~now_v & old_v);
endmodule

// File: rtl/irq_port_watch.sv
module irq_port_watch #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins,
    input  logic         rd_stb,
    output logic         diff
);
    logic [W-1:0] st1, st2, snap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st1  <= '0;
            st2  <= '0;
            snap <= '0;
        end else begin
            st1 <= pins;
            st2 <= st1;
            if (rd_stb) snap <= st2;
        end
    end

    assign diff = |(st2 ^ snap);

    assert_snap_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_stb) |-> (snap == $past(st2)));
endmodule

// File: rtl/irq_ctl_regs.sv
module irq_ctl_regs
    import irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic [7:0]      wdata,
    input  logic [NSRC-1:0] hw_set,
    input  logic            take,
    input  logic            reti,
    output logic [7:0]      rdata,
    output logic            gie,
    output logic [NSRC-1:0] en,
    output logic [NSRC-1:0] flg
);
    logic [NSRC-1:0] flg_sw;

    always_comb begin
        flg_sw = wr ? wdata[FLG_LO +: NSRC] : flg;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gie <= 1'b0;
            en  <= '0;
            flg <= '0;
        end else begin
            if (take)      gie <= 1'b0;
            else if (reti) gie <= 1'b1;
            else if (wr)   gie <= wdata[GIE_B];
            if (wr) en <= wdata[EN_LO +: NSRC];
            flg <= flg_sw | hw_set;
        end
    end

    always_comb begin
        rdata = 8'h00;
        rdata[GIE_B] = gie;
        rdata[EN_LO +: NSRC] = en;
        rdata[FLG_LO +: NSRC] = flg;
    end

    assert_timer_flag_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(hw_set[SRC_TMR]) |-> flg[SRC_TMR]);

    assert_flags_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr) |-> ((flg & $past(flg)) == $past(flg)));

    assert_reti_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(reti) && !$past(take)) |-> gie);
endmodule

// File: rtl/irq_seq.sv
module irq_seq
    import irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pending,
    input  logic ack,
    output logic req,
    output logic push,
    output logic take
);
    irq_state_t st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (pending) st_d = ST_REQ;
            ST_REQ: begin
                if (ack)           st_d = ST_PUSH;
                else if (!pending) st_d = ST_IDLE;
            end
            ST_PUSH: st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_comb begin
        req  = 1'b0;
        push = 1'b0;
        unique case (st_q)
            ST_IDLE: ;
            ST_REQ:  req  = 1'b1;
            ST_PUSH: push = 1'b1;
            default: ;
        endcase
        take = req & ack;
    end

    assert_push_after_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ack) |=> (push && !req));

    assert_push_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> !push);

    assert_withdraw_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ack && !pending) |=> !req);
endmodule

// File: rtl/mcu_irq_unit.sv
module mcu_irq_unit
    import irq_pkg::*;
#(
    parameter int          VEC_W       = 16,
    parameter logic [15:0] VECTOR      = 16'h0004,
    parameter int          PORT_W      = 4,
    parameter int          SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_pin,
    input  logic              ext_rise_sel,
    input  logic              tmr_ovf,
    input  logic [PORT_W-1:0] port_hi,
    input  logic              port_rd,
    input  logic              ctl_wr,
    input  logic [7:0]        ctl_wdata,
    output logic [7:0]        ctl_rdata,
    input  logic              irq_ack,
    input  logic              reti,
    output logic              irq_req,
    output logic              push_ret,
    output logic [VEC_W-1:0]  vec_addr
);
    logic            ext_evt, pch_evt, take, gie, pending;
    logic [NSRC-1:0] hw_set, en, flg;

    irq_edge_sync #(.STAGES(SYNC_STAGES)) u_ext (
        .clk(clk), .rst_n(rst_n), .pin(ext_pin),
        .rise_sel(ext_rise_sel), .evt(ext_evt)
    );

    irq_port_watch #(.W(PORT_W)) u_port (
        .clk(clk), .rst_n(rst_n), .pins(port_hi),
        .rd_stb(port_rd), .diff(pch_evt)
    );

    always_comb begin
        hw_set = '0;
        hw_set[SRC_TMR] = tmr_ovf;
        hw_set[SRC_EXT] = ext_evt;
        hw_set[SRC_PCH] = pch_evt;
    end

    irq_ctl_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr(ctl_wr), .wdata(ctl_wdata),
        .hw_set(hw_set), .take(take), .reti(reti), .rdata(ctl_rdata),
        .gie(gie), .en(en), .flg(flg)
    );

    assign pending = gie & |(en & flg);

    irq_seq u_seq (
        .clk(clk), .rst_n(rst_n), .pending(pending), .ack(irq_ack),
        .req(irq_req), .push(push_ret), .take(take)
    );

    assign vec_addr = VEC_W'(VECTOR);

    assert_req_needs_gie_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> $past(gie));

    assert_gie_off_at_push_R7: assert property (@(posedge clk) disable iff (!rst_n)
        push_ret |-> !ctl_rdata[GIE_B]);

    assert_bit6_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rdata[6] == 1'b0);
endmodule

// File: tb/mcu_irq_unit_test.sv
module mcu_irq_unit_test;
    timeunit 1ns;
    timeprecision 100ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_pin = 1'b0, ext_rise_sel = 1'b1, tmr_ovf = 1'b0;
    logic [3:0]  port_hi = 4'h0;
    logic        port_rd = 1'b0, ctl_wr = 1'b0, irq_ack = 1'b0, reti = 1'b0;
    logic [7:0]  ctl_wdata = 8'h00;
    logic [7:0]  ctl_rdata;
    logic        irq_req, push_ret;
    logic [15:0] vec_addr;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mcu_irq_unit uut (
        .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .ext_rise_sel(ext_rise_sel),
        .tmr_ovf(tmr_ovf), .port_hi(port_hi), .port_rd(port_rd),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .irq_ack(irq_ack), .reti(reti), .irq_req(irq_req),
        .push_ret(push_ret), .vec_addr(vec_addr)
    );

    // vector: [18:11] control written, [10:9] source (1 timer, 2 ext rise, 3 port),
    // [8] expected request, [7:0] expected register read
    localparam logic [18:0] VEC [6] = '{
        {8'h20, 2'd1, 1'b0, 8'h24},
        {8'hA0, 2'd1, 1'b1, 8'hA4},
        {8'h90, 2'd2, 1'b1, 8'h92},
        {8'hA0, 2'd2, 1'b0, 8'hA2},
        {8'h88, 2'd3, 1'b1, 8'h89},
        {8'h80, 2'd1, 1'b0, 8'h84}
    };

    task automatic tick(input int n = 1);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_ctl(input logic [7:0] d);
        ctl_wr = 1'b1; ctl_wdata = d;
        tick();
        ctl_wr = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        tick(2);
        // R1 reset state
        chk("R1 rdata", 16'(ctl_rdata), 16'h00);
        chk("R1 req", 16'(irq_req), 16'h0);
        chk("R1 push", 16'(push_ret), 16'h0);
        rst_n = 1'b1;
        tick(2);
        chk("R7 vector", vec_addr, 16'h0004);

        // R2 layout, bit6 reads 0
        wr_ctl(8'hFF);
        chk("R2 readback", 16'(ctl_rdata), 16'hBF);
        wr_ctl(8'h00);
        tick(2);

        // vector table
        for (int i = 0; i < 6; i++) begin
            ext_pin = 1'b0; port_hi = 4'h0;
            tick(4);
            port_rd = 1'b1; tick(); port_rd = 1'b0;
            wr_ctl(VEC[i][18:11]);
            case (VEC[i][10:9])
                2'd1: begin tmr_ovf = 1'b1; tick(); tmr_ovf = 1'b0; end
                2'd2: ext_pin = 1'b1;
                2'd3: port_hi = 4'h5;
                default: ;
            endcase
            tick(5);
            chk($sformatf("R6 vec%0d rdata", i), 16'(ctl_rdata), 16'(VEC[i][7:0]));
            chk($sformatf("R6 vec%0d req", i), 16'(irq_req), 16'(VEC[i][8]));
        end
        ext_pin = 1'b0; port_hi = 4'h0;
        tick(4);
        port_rd = 1'b1; tick(); port_rd = 1'b0;
        wr_ctl(8'h10);

        // R4 rising edge: flag at third edge
        ext_rise_sel = 1'b1;
        ext_pin = 1'b1;
        tick(2);
        chk("R4 rise early", 16'(ctl_rdata[1]), 16'h0);
        tick();
        chk("R4 rise flag", 16'(ctl_rdata[1]), 16'h1);
        wr_ctl(8'h10);
        ext_pin = 1'b0;
        tick(5);
        chk("R4 fall ignored", 16'(ctl_rdata), 16'h10);
        // R4 falling edge mode
        ext_rise_sel = 1'b0;
        ext_pin = 1'b1;
        tick(5);
        chk("R4 rise ignored", 16'(ctl_rdata), 16'h10);
        ext_pin = 1'b0;
        tick(3);
        chk("R4 fall flag", 16'(ctl_rdata), 16'h12);
        ext_rise_sel = 1'b1;
        wr_ctl(8'h08);

        // R5 port change and snapshot reload
        port_hi = 4'hA;
        tick(3);
        chk("R5 change flag", 16'(ctl_rdata), 16'h09);
        port_rd = 1'b1; tick(); port_rd = 1'b0;
        wr_ctl(8'h08);
        tick(3);
        chk("R5 after read", 16'(ctl_rdata), 16'h08);

        // R6 request timing, R7 take, R8 sticky flags
        wr_ctl(8'hA0);
        tmr_ovf = 1'b1; tick(); tmr_ovf = 1'b0;
        chk("R3 flag next edge", 16'(ctl_rdata), 16'hA4);
        chk("R6 req not yet", 16'(irq_req), 16'h0);
        tick();
        chk("R6 req raised", 16'(irq_req), 16'h1);
        irq_ack = 1'b1; tick(); irq_ack = 1'b0;
        chk("R7 push", 16'(push_ret), 16'h1);
        chk("R7 req low", 16'(irq_req), 16'h0);
        chk("R8 flags kept gie off", 16'(ctl_rdata), 16'h24);
        tick();
        chk("R7 push single", 16'(push_ret), 16'h0);
        tick(2);
        chk("R6 no req without gie", 16'(irq_req), 16'h0);

        // R9 reti
        reti = 1'b1; tick(); reti = 1'b0;
        chk("R9 gie set", 16'(ctl_rdata), 16'hA4);
        tick();
        chk("R9 req again", 16'(irq_req), 16'h1);

        // R11 withdraw: clear timer enable, keep flag
        wr_ctl(8'h84);
        tick();
        chk("R11 req dropped", 16'(irq_req), 16'h0);
        chk("R11 flag kept", 16'(ctl_rdata), 16'h84);

        // R10 write vs hardware set
        ctl_wr = 1'b1; ctl_wdata = 8'h00; tmr_ovf = 1'b1;
        tick();
        ctl_wr = 1'b0; tmr_ovf = 1'b0;
        chk("R10 hw wins", 16'(ctl_rdata), 16'h04);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule